// File: doc/BRIEF.md
# Masked Interrupt and DMA Request Router

This block gathers the event bits of a card-interface controller into a sticky request register. It turns that register into one level-sensitive CPU interrupt and two DMA request levels, one for receive and one for transmit. Each event source gives a one-cycle set pulse on its own bit. The request bit then stays high until the clear that belongs to it arrives. A CPU-writable mask register takes an event out of the interrupt.

The FIFO service requests can go to the DMA engine instead of the CPU. When the DMA-enable control bit is high, the receive and transmit FIFO request bits count as masked for the interrupt, whatever the mask register holds. The same two bits then drive the receive and transmit DMA request lines. FIFO accesses clear these two bits, and they can be raised again by the FIFO logic. Clock-control commands set and clear the clock-off request bit. The current request and mask registers can be read back through two status ports.

Top module: `irq_router`

## Requirements
- R1: A one-cycle pulse on `evtSet[i]` sets request bit i at the next clock edge. The bit stays set until a clear that applies to that bit. Bits 0..3 and 7..12 have no clear other than reset. Bit meanings: 0 data done, 1 program done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO request, 6 transmit FIFO request, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 SDIO interrupt, 12 SDIO acknowledge.
- R2: A mask write (`maskWrEn` high) loads `maskWrData[12:0]` into the 13-bit mask register and ignores bits 31:13. `maskStatus` shows the stored value.
- R3: `irqOut` is high when some request bit is set whose effective mask bit is clear. A set mask bit keeps its event out of the interrupt.
- R4: While `dmaEn` is high, request bits 5 and 6 are in the effective mask, whatever the mask register holds.
- R5: `rxDmaReq` equals request bit 5 and `txDmaReq` equals request bit 6 while `dmaEn` is high. Both are low while `dmaEn` is low.
- R6: `clkStart` clears request bit 4 and `clkStop` sets it. When both come in the same cycle, the bit ends up set.
- R7: `rxFifoRd` clears request bit 5 and `txFifoWr` clears request bit 6. No other bit changes.
- R8: When a set pulse and a clear strobe hit the same bit in the same cycle, the bit ends up set.
- R9: `irqOut`, `rxDmaReq` and `txDmaReq` are registered. They reflect the request, mask and `dmaEn` values of the cycle before the clock edge, so a set pulse reaches `irqOut` two edges later.
- R10: After reset the request register, the mask register and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 13 | One set pulse per event bit |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 32 | Mask write data; only bits 12:0 are kept |
| dmaEn | input | 1 | Sends FIFO requests to the DMA lines |
| rxFifoRd | input | 1 | CPU receive FIFO read; clears bit 5 |
| txFifoWr | input | 1 | CPU transmit FIFO write; clears bit 6 |
| clkStart | input | 1 | Clock-start command; clears bit 4 |
| clkStop | input | 1 | Clock-stop command; sets bit 4 |
| irqOut | output | 1 | CPU interrupt level |
| rxDmaReq | output | 1 | Receive DMA request level |
| txDmaReq | output | 1 | Transmit DMA request level |
| reqStatus | output | 13 | Request register readback |
| maskStatus | output | 13 | Mask register readback |

## Verification
The assertions check the following on every cycle:
- both DMA lines are low one cycle after `dmaEn` was low;
- a set pulse always ends up in the request register, even against a clear;
- `clkStop` always sets the clock-off bit;
- a mask write stores only its low 13 bits;
- with `dmaEn` high, the FIFO request bits alone never raise the interrupt.

The bench scenarios show the rest:
- the two-edge latency from a set pulse to `irqOut`;
- the exact clears by FIFO accesses and by the clock-start command;
- the effect of moving the mask while requests stay pending;
- the sticky behaviour of the bits that have no clear.

A cycle-by-cycle reference model in the bench produces these expected results.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int EVT_W      = 13;
  localparam int CLKOFF_BIT = 4;
  localparam int RX_BIT     = 5;
  localparam int TX_BIT     = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic [EVT_W-1:0] clrVec;   // bits to clear this cycle
    logic [EVT_W-1:0] setVec;   // bits forced set by commands
    logic             maskLoad; // load mask register
    logic             steer;    // route FIFO requests to DMA
  } ctrlStrb_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic      rxFifoRd,
  input  logic      txFifoWr,
  input  logic      clkStart,
  input  logic      clkStop,
  input  logic      maskWrEn,
  input  logic      dmaEn,
  output ctrlStrb_t strb
);
  always_comb begin
    strb = '0;
    strb.clrVec[RX_BIT]     = rxFifoRd;
    strb.clrVec[TX_BIT]     = txFifoWr;
    strb.clrVec[CLKOFF_BIT] = clkStart;
    strb.setVec[CLKOFF_BIT] = clkStop;
    strb.maskLoad           = maskWrEn;
    strb.steer              = dmaEn;
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [EVT_W-1:0] evtSet,
  input  logic [EVT_W-1:0] maskIn,
  output logic             irqOut,
  output logic             rxDmaReq,
  output logic             txDmaReq,
  output logic [EVT_W-1:0] reqStatus,
  output logic [EVT_W-1:0] maskStatus
);
  logic [EVT_W-1:0] steerMask;
  logic [EVT_W-1:0] reqQ, reqNext, maskQ, effMask;
  logic irqD, rxD, txD;

  // Steering mask built per bit
  for (genvar i = 0; i < EVT_W; i++) begin : g_steer
    assign steerMask[i] = (i == RX_BIT) || (i == TX_BIT);
  end

  // Set pulses take priority over clears
  assign reqNext = (reqQ & ~strb.clrVec) | strb.setVec | evtSet;
  assign effMask = maskQ | (strb.steer ? steerMask : '0);
  assign irqD    = |(reqQ & ~effMask);
  assign rxD     = strb.steer & reqQ[RX_BIT];
  assign txD     = strb.steer & reqQ[TX_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ     <= '0;
      maskQ    <= '0;
      irqOut   <= 1'b0;
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
    end else begin
      reqQ     <= reqNext;
      if (strb.maskLoad) maskQ <= maskIn;
      irqOut   <= irqD;
      rxDmaReq <= rxD;
      txDmaReq <= txD;
    end
  end

  assign reqStatus  = reqQ;
  assign maskStatus = maskQ;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtSet,
  input  logic              maskWrEn,
  input  logic [DATA_W-1:0] maskWrData,
  input  logic              dmaEn,
  input  logic              rxFifoRd,
  input  logic              txFifoWr,
  input  logic              clkStart,
  input  logic              clkStop,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic [EVT_W-1:0]  reqStatus,
  output logic [EVT_W-1:0]  maskStatus
);
  ctrlStrb_t strb;
  logic      unusedHiBits;

  // Upper write bits are dropped
  assign unusedHiBits = ^maskWrData[DATA_W-1:EVT_W];

  irq_router_ctrl i_ctrl (
    .rxFifoRd(rxFifoRd), .txFifoWr(txFifoWr), .clkStart(clkStart),
    .clkStop(clkStop), .maskWrEn(maskWrEn), .dmaEn(dmaEn), .strb(strb)
  );

  irq_router_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtSet(evtSet),
    .maskIn(maskWrData[EVT_W-1:0]), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .reqStatus(reqStatus), .maskStatus(maskStatus)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [EVT_W-1:0] evtSet,
  input logic             maskWrEn,
  input logic [31:0]      maskWrData,
  input logic             dmaEn,
  input logic             clkStop,
  input logic             irqOut,
  input logic             rxDmaReq,
  input logic             txDmaReq,
  input logic [EVT_W-1:0] reqStatus,
  input logic [EVT_W-1:0] maskStatus
);
  localparam logic [EVT_W-1:0] FIFO_BITS = EVT_W'((1 << RX_BIT) | (1 << TX_BIT));

  AST_RX_DMA_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn |=> !rxDmaReq); // R5
  AST_TX_DMA_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn |=> !txDmaReq); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((reqStatus & $past(evtSet)) == $past(evtSet))); // R8
  AST_CLKOFF_SET: assert property (@(posedge clk) disable iff (!rstN)
    clkStop |=> reqStatus[CLKOFF_BIT]); // R6
  AST_MASK_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> (maskStatus == $past(maskWrData[EVT_W-1:0]))); // R2
  AST_DMA_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEn && ((reqStatus & ~maskStatus & ~FIFO_BITS) == '0)) |=> !irqOut); // R4
endmodule

bind irq_router irq_router_chk i_chk (
  .clk(clk), .rstN(rstN), .evtSet(evtSet), .maskWrEn(maskWrEn),
  .maskWrData(maskWrData), .dmaEn(dmaEn), .clkStop(clkStop),
  .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
  .reqStatus(reqStatus), .maskStatus(maskStatus)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  logic        clk = 0;
  logic        rstN = 0;
  logic [12:0] evtSet = '0;
  logic        maskWrEn = 0;
  logic [31:0] maskWrData = '0;
  logic        dmaEn = 0, rxFifoRd = 0, txFifoWr = 0, clkStart = 0, clkStop = 0;
  logic        irqOut, rxDmaReq, txDmaReq;
  logic [12:0] reqStatus, maskStatus;

  int tests = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    logic irq, rx, tx;
    logic [12:0] req, mask;
    string tag;
  } item_t;
  item_t sbq[$];

  logic [12:0] mReq = '0, mMask = '0;

  always #2 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .dmaEn(dmaEn), .rxFifoRd(rxFifoRd),
    .txFifoWr(txFifoWr), .clkStart(clkStart), .clkStop(clkStop),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .reqStatus(reqStatus), .maskStatus(maskStatus)
  );

  // Driver: drives one cycle at the falling edge, queues the expected result
  task automatic step(input logic [12:0] e, input logic mwe, input logic [31:0] mwd,
                      input logic d, input logic rd, input logic wr,
                      input logic st, input logic sp, input string tag);
    item_t it;
    logic [12:0] eff, clr, setv;
    evtSet = e; maskWrEn = mwe; maskWrData = mwd; dmaEn = d;
    rxFifoRd = rd; txFifoWr = wr; clkStart = st; clkStop = sp;
    // R3/R4/R5/R9: registered outputs come from the state before this edge
    eff = mMask | (d ? 13'h0060 : 13'h0);
    it.irq = |(mReq & ~eff);
    it.rx = d & mReq[5];
    it.tx = d & mReq[6];
    clr = '0; setv = '0;
    clr[5] = rd; clr[6] = wr; clr[4] = st; setv[4] = sp;
    mReq = (mReq & ~clr) | setv | e;
    if (mwe) mMask = mwd[12:0];
    it.req = mReq; it.mask = mMask; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input logic d, input string tag);
    step('0, 0, '0, d, 0, 0, 0, 0, tag);
  endtask

  // Monitor: samples 1 ns after the rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        tests++;
        if (irqOut !== it.irq || rxDmaReq !== it.rx || txDmaReq !== it.tx ||
            reqStatus !== it.req || maskStatus !== it.mask) begin
          fails++;
          $display("FAIL %s: got irq=%b rx=%b tx=%b req=%h mask=%h exp irq=%b rx=%b tx=%b req=%h mask=%h",
                   it.tag, irqOut, rxDmaReq, txDmaReq, reqStatus, maskStatus,
                   it.irq, it.rx, it.tx, it.req, it.mask);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++; // R10 reset state
    if ({irqOut, rxDmaReq, txDmaReq} !== 3'b000 || reqStatus !== '0 || maskStatus !== '0) begin
      fails++;
      $display("FAIL R10: got irq=%b rx=%b tx=%b req=%h mask=%h exp all zero",
               irqOut, rxDmaReq, txDmaReq, reqStatus, maskStatus);
    end
    rstN = 1;
    @(negedge clk);
    idle(0, "R10 idle after reset");
    // R1 + R9: receive request, DMA off, so it goes to the interrupt
    step(13'h0020, 0, '0, 0, 0, 0, 0, 0, "R1 set rx bit");
    idle(0, "R9 irq one edge later");
    idle(0, "R5 dma lines low while disabled");
    // R4/R5: enable DMA
    idle(1, "R4 rx request steered off irq");
    idle(1, "R5 rx dma request high");
    // R7: receive FIFO read clears bit 5
    step('0, 0, '0, 1, 1, 0, 0, 0, "R7 rx read clears bit5");
    idle(1, "R7 rx dma drops");
    // R8: transmit set and clear together
    step(13'h0040, 0, '0, 1, 0, 1, 0, 0, "R8 set beats tx clear");
    idle(1, "R5 tx dma request high");
    step('0, 0, '0, 1, 0, 1, 0, 0, "R7 tx write clears bit6");
    idle(1, "R7 tx dma drops");
    // Pending tx with DMA turned off goes back to irq
    step(13'h0040, 0, '0, 1, 0, 0, 0, 0, "R1 set tx bit");
    idle(0, "R4 tx back on irq when dma off");
    idle(0, "R5 tx dma low when disabled");
    step('0, 0, '0, 0, 0, 1, 0, 0, "R7 clear tx");
    idle(0, "R3 irq falls");
    // R6: clock commands
    step('0, 0, '0, 0, 0, 0, 0, 1, "R6 clock stop sets bit4");
    idle(0, "R6 clock off irq");
    step('0, 0, '0, 0, 0, 0, 1, 0, "R6 clock start clears bit4");
    step('0, 0, '0, 0, 0, 0, 1, 1, "R6 start and stop together set");
    idle(0, "R6 bit4 held");
    step('0, 0, '0, 0, 0, 0, 1, 0, "R6 clear bit4");
    idle(0, "R6 irq low");
    // R2/R3: masking
    step('0, 1, 32'hFFFF_E001, 0, 0, 0, 0, 0, "R2 upper mask bits dropped");
    step(13'h0001, 0, '0, 0, 0, 0, 0, 0, "R3 masked data done");
    idle(0, "R3 masked event gives no irq");
    idle(0, "R1 bit0 sticky");
    step('0, 1, 32'h0000_0000, 0, 0, 0, 0, 0, "R3 unmask bit0");
    idle(0, "R3 irq after unmask");
    idle(0, "R1 bit0 still set");
    step('0, 1, 32'h0000_1FFF, 0, 0, 0, 0, 0, "R2 mask all");
    idle(0, "R3 irq low fully masked");
    step(13'h1F80, 0, '0, 0, 0, 0, 0, 0, "R1 set bits 7 to 12");
    idle(0, "R1 high bits latched, masked");
    step('0, 1, 32'h0000_0FFF, 0, 0, 0, 0, 0, "R3 unmask bit12");
    idle(0, "R3 irq from bit12");
    // R4 with every non-FIFO bit masked and FIFO requests pending
    step(13'h0060, 1, 32'h0000_1F9F, 1, 0, 0, 0, 0, "R4 only fifo bits unmasked");
    idle(1, "R4 no irq from fifo bits");
    idle(1, "R5 both dma lines");
    idle(0, "R4 irq when dma disabled");
    idle(0, "R9 settle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule